// File: doc/BRIEF.md
# Programmable Down-Counter Timer With Compare

This block is a 32-bit periodic timer that software drives through a small word-addressed register file. A down-counter is advanced by a count enable. That enable comes from one of three synchronous tick inputs, picked by a clock-source field and then divided by a 12-bit prescaler. When the counter passes zero it either reloads from a load register or wraps to all ones.

A compare register is checked against the count on every counting step. A match latches a status flag, and software clears that flag by writing a one to it. The flag, gated by the compare-interrupt enable and the timer enable, drives a level interrupt.

A self-clearing software-reset control bit returns most of the state to its defaults but keeps the enable and low-power control bits. A separate start-mode bit decides whether enabling the timer restarts the count or resumes it. Writing the load register can also overwrite the running count at once.

Top module: `dctimer`

## Requirements
- R1: Register word index = addr[ADDR_W-1:2]: 0 control, 1 status, 2 load, 3 compare, 4 count. Other indices read 0 and ignore writes. The count register is read-only, writes to it are ignored, and it reads the live count.
- R2: A control write stores only wdata[25:0], and control bits 31:26 always read 0. Bit positions: 0 enable, 1 start-mode, 2 compare-irq-enable, 3 reload, 15:4 prescale, 16 soft-reset, 17 overwrite, 18/19/21/22 low-power/debug keep bits, 25:24 clock source.
- R3: Clock source 00 = no tick (count frozen), 01 = tick_main, 10 = tick_fast, 11 = tick_slow. Ticks on unselected inputs have no effect on the count.
- R4: While enabled, the count steps once per (prescale+1) selected ticks. The prescale divider restarts when enable rises through a control write.
- R5: A control write with bit 16 set keeps only bits 0, 1, 18, 19, 21 and 22 of the written value and reads back with bit 16 clear. It clears status and compare and sets load to 0xFFFF_FFFF. The count becomes 0xFFFF_FFFF if the kept enable is 1, and 0 otherwise.
- R6: When a control write raises enable with start-mode set, the count loads the load value if reload is set and 0xFFFF_FFFF if not. With start-mode clear, the count resumes from its held value.
- R7: A step at count 0 loads the load value in reload mode and 0xFFFF_FFFF otherwise. Any other step decrements the count, and the count holds while disabled.
- R8: A load write with the overwrite bit (17) set copies the new value into the count in the same cycle, whether or not reload is set. With bit 17 clear the count is untouched.
- R9: A step taken while count equals compare sets status bit 0. Writing status with wdata[0]=1 clears it, and writing wdata[0]=0 leaves it set.
- R10: irq is high exactly when status, compare-irq-enable and enable are all 1.
- R11: After rst_n the control, status, compare and count registers read 0 and load reads 0xFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address, word index in bits ADDR_W-1:2 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tick_main | input | 1 | Main peripheral clock tick enable |
| tick_fast | input | 1 | High-frequency clock tick enable |
| tick_slow | input | 1 | 32 kHz clock tick enable |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the tick inputs are single-cycle synchronous enables. They also assume that software does not clear status in the same cycle that a compare match sets it. The bench drives one register access at a time and never pulses ticks during a write, so write-versus-step ordering never has to be resolved. Count checks are taken only after whole runs of ticks, so the expected value is the start count minus the number of complete prescale periods in the run.

// File: rtl/dctimer.sv
module dctimer #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              tick_main,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  localparam int          CTRL_W = 26;
  localparam int          PSC_W  = 12;
  localparam int          IDX_W  = ADDR_W - 2;
  localparam logic [31:0] ALL1   = 32'hFFFF_FFFF;
  localparam logic [CTRL_W-1:0] KEEP = 26'h06C_0003;

  logic [CTRL_W-1:0] ctrl;
  logic              stat;
  logic [31:0]       ld, cmpv, cnt;
  logic [PSC_W-1:0]  pcnt;
  logic              src;

  wire [IDX_W-1:0] idx = addr[ADDR_W-1:2];
  wire wr_ctl = wr_en && idx == IDX_W'(0);
  wire wr_st  = wr_en && idx == IDX_W'(1);
  wire wr_ld  = wr_en && idx == IDX_W'(2);
  wire wr_cmp = wr_en && idx == IDX_W'(3);

  wire             en    = ctrl[0];
  wire             ocien = ctrl[2];
  wire             rld   = ctrl[3];
  wire [PSC_W-1:0] psc   = ctrl[4 +: PSC_W];
  wire             iovw  = ctrl[17];

  wire swr     = wr_ctl && wdata[16];
  wire en_rise = wr_ctl && !wdata[16] && wdata[0] && !en;
  wire step    = en && src && (pcnt >= psc);
  wire match   = step && (cnt == cmpv);
  wire [31:0] next_wrap = rld ? ld : ALL1;

  always_comb begin
    case (ctrl[25:24])
      2'b01:   src = tick_main;
      2'b10:   src = tick_fast;
      2'b11:   src = tick_slow;
      default: src = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      stat <= 1'b0;
      ld   <= ALL1;
      cmpv <= '0;
      cnt  <= '0;
      pcnt <= '0;
    end else begin
      if (wr_ctl)
        ctrl <= swr ? (wdata[CTRL_W-1:0] & KEEP) : wdata[CTRL_W-1:0];

      if (swr || en_rise)
        pcnt <= '0;
      else if (en && src)
        pcnt <= (pcnt >= psc) ? '0 : pcnt + 1'b1;

      if (swr)
        stat <= 1'b0;
      else if (match)
        stat <= 1'b1;
      else if (wr_st && wdata[0])
        stat <= 1'b0;

      if (swr)
        ld <= ALL1;
      else if (wr_ld)
        ld <= wdata;

      if (swr)
        cmpv <= '0;
      else if (wr_cmp)
        cmpv <= wdata;

      if (swr)
        cnt <= wdata[0] ? ALL1 : '0;
      else if (wr_ld && iovw)
        cnt <= wdata;
      else if (en_rise && wdata[1])
        cnt <= wdata[3] ? ld : ALL1;
      else if (step)
        cnt <= (cnt == '0) ? next_wrap : cnt - 1'b1;
    end
  end

  assign irq = stat & ocien & en;

  always_comb begin
    case (idx)
      IDX_W'(0): rdata = {{(32-CTRL_W){1'b0}}, ctrl};
      IDX_W'(1): rdata = {31'd0, stat};
      IDX_W'(2): rdata = ld;
      IDX_W'(3): rdata = cmpv;
      IDX_W'(4): rdata = cnt;
      default:   rdata = '0;
    endcase
  end

  assert_decrement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != '0 && !wr_en) |=> cnt == $past(cnt) - 32'd1);
  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(cnt));
  assert_match_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == cmpv && !swr) |=> stat);
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && wdata[0] && !match) |=> !stat);
  assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (ld == ALL1 && cmpv == '0 && !stat && !ctrl[16]));
  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat);
endmodule

// File: tb/dctimer_tb.sv
module dctimer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic tick_main = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
  logic irq;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  dctimer #(.ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_main(tick_main), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 12'(a);
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    @(negedge clk);
    {tick_slow, tick_fast, tick_main} = m;
    repeat (n) @(posedge clk);
    @(negedge clk);
    {tick_slow, tick_fast, tick_main} = 3'b000;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd(0, v);  check("R11 ctrl", v, 0);
    rd(4, v);  check("R11 status", v, 0);
    rd(8, v);  check("R11 load", v, 32'hFFFF_FFFF);
    rd(12, v); check("R11 cmp", v, 0);
    rd(16, v); check("R11 count", v, 0);
    check("R11 irq", {31'd0, irq}, 0);

    wr(0, 32'hFFFE_FFF0);
    rd(0, v); check("R2 upper bits", v, 32'h03FE_FFF0);
    wr(0, 0);

    // R3 R4 sweep over source and prescale
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 6; p++) begin
        for (int n = 1; n < 14; n += 4) begin
          logic [2:0] m;
          int exp;
          m = (s == 0) ? 3'b111 : 3'b001 << (s - 1);
          wr(0, 0);
          wr(8, 1000);
          wr(0, (s << 24) | (p << 4) | 32'hB);
          pulse(~m, 5);
          pulse(m, n);
          exp = (s == 0) ? 1000 : 1000 - n / (p + 1);
          rd(16, v);
          check(s == 0 ? "R3 no clock" : "R4 prescale", v, 32'(exp));
        end
      end
    end

    wr(0, 0); wr(8, 3); wr(0, 32'h0100_000B);
    pulse(3'b001, 4); rd(16, v); check("R7 reload wrap", v, 3);
    pulse(3'b001, 1); rd(16, v); check("R7 after reload", v, 2);

    wr(0, 0); wr(0, 32'h0102_0003);
    rd(16, v); check("R6 start max", v, 32'hFFFF_FFFF);
    wr(8, 2); rd(16, v); check("R8 overwrite", v, 2);
    pulse(3'b001, 3); rd(16, v); check("R7 free wrap", v, 32'hFFFF_FFFF);

    wr(0, 0); wr(0, 32'h0100_0003);
    wr(8, 7); rd(16, v); check("R8 no overwrite", v, 32'hFFFF_FFFF);
    pulse(3'b001, 5);
    wr(0, 0); rd(16, held);
    check("R7 held", held, 32'hFFFF_FFFA);
    wr(0, 32'h0100_0001); rd(16, v); check("R6 resume", v, held);
    pulse(3'b001, 2); rd(16, v); check("R6 resume count", v, held - 2);

    wr(0, 0); wr(8, 10); wr(12, 5); wr(4, 1);
    wr(0, 32'h0100_000F);
    pulse(3'b001, 5);
    rd(4, v); check("R9 no early match", v, 0);
    check("R10 irq low", {31'd0, irq}, 0);
    pulse(3'b001, 1);
    rd(4, v); check("R9 match", v, 1);
    check("R10 irq high", {31'd0, irq}, 1);
    wr(4, 0); rd(4, v); check("R9 write zero", v, 1);
    wr(0, 32'h0100_000B);
    check("R10 gated by enable bit", {31'd0, irq}, 0);
    wr(0, 32'h0100_000F);
    check("R10 regated", {31'd0, irq}, 1);
    wr(4, 1); rd(4, v); check("R9 clear", v, 0);
    check("R10 irq cleared", {31'd0, irq}, 0);

    wr(0, 0);
    for (int a = 5; a < 8; a++) begin
      rd(a * 4, v); check("R1 undefined read", v, 0);
    end
    rd(16, held);
    wr(16, 32'h1234); rd(16, v); check("R1 count read-only", v, held);
    wr(24, 32'h55); rd(8, v); check("R1 undefined write load", v, 10);
    rd(12, v); check("R1 undefined write cmp", v, 5);

    wr(0, 32'h016C_003F);
    wr(0, 32'h016D_003F);
    rd(0, v);  check("R5 kept ctrl", v, 32'h006C_0003);
    rd(8, v);  check("R5 load", v, 32'hFFFF_FFFF);
    rd(12, v); check("R5 cmp", v, 0);
    rd(16, v); check("R5 count enabled", v, 32'hFFFF_FFFF);
    pulse(3'b111, 3); rd(16, v); check("R3 frozen after soft reset", v, 32'hFFFF_FFFF);
    wr(0, 32'h0001_0000);
    rd(16, v); check("R5 count disabled", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule